// File: doc/BRIEF.md
# SKP Elastic Rate-Match Buffer

This block sits on the receive path of a 128b/130b serial link. Words arrive in the recovered clock domain and are handed to the local clock domain. It absorbs a frequency offset of up to ±300 ppm between the far-end transmitter and the local clock. It does this by changing the length of SKP ordered sets, one 32-bit word (four SKP symbols of value 0xAA) at a time. Data words are passed through untouched and in order.

The block aligner marks each incoming word that belongs to a SKP ordered set with `wr_skp`. Consecutive marked words form one set, and the next valid unmarked word closes that set.

On the write side, the fill level is the number of words written minus the number of words read, as seen through the pointer synchronizer. That fill level decides whether a set is left alone, shortened or lengthened. The read side pops one word per accepted request. It also exposes sticky event flags in its own domain. Pointers cross between the domains as Gray codes through two-flop synchronizers.

Top module: `skp_elastic_buf`

## Requirements
- R1: Every valid non-SKP word is read out unchanged and in write order. After a request (`rd_en`) on a non-empty buffer, `rd_valid` is high with the word on the following read-clock cycle.
- R2: A SKP word is discarded when three things hold: it is not the first of its set, no adjustment has yet been made in that set, and the fill is at or above 12. `sts_skp_dropped` then becomes set.
- R3: The first SKP word of a set that arrives with a fill of at most 4 is stored twice as 0xAAAAAAAA. `sts_skp_added` becomes set when that set closes with the extra word still in it.
- R4: A set holding a single SKP word is never shortened. The drop request waits for a later set.
- R5: A set that was lengthened never exceeds five stored SKP words. A further SKP word in it is discarded, which withdraws the addition, so `sts_skp_added` is not set for that set.
- R6: At most one adjustment (add or drop) is made in any one SKP set.
- R7: A word that would be stored while the fill is 16 is discarded, and `sts_overflow` becomes set.
- R8: A read request on an empty buffer gives `rd_valid` low on the next cycle and sets `sts_underflow`.
- R9: After reset `rd_valid` and all four status flags are low. Every status flag stays set until the next reset.
- R10: The write pointer published to the read domain changes by at most one Gray bit per write-clock cycle, even when two words are stored in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| rd_clk | input | 1 | Local (read) clock |
| arst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_valid | input | 1 | Incoming word is valid |
| wr_skp | input | 1 | Incoming word is a SKP word of a SKP ordered set |
| wr_data | input | 32 | Incoming word |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | `rd_data` holds a popped word |
| rd_data | output | 32 | Outgoing word |
| sts_overflow | output | 1 | Sticky: a word was lost to a full buffer |
| sts_underflow | output | 1 | Sticky: read requested while empty |
| sts_skp_added | output | 1 | Sticky: a SKP word was added to a set |
| sts_skp_dropped | output | 1 | Sticky: a SKP word was removed from a set |

## Verification
The bench builds the block with its defaults: a depth of 16, thresholds of 12 and 4, and a five-word set limit. It sweeps every prefill level from 0 to 15 against every SKP set length from 1 to 5, then drains the buffer and checks one extra read. This reaches the add at low fill, the drop at high fill, the single-word set that cannot be shortened, and the withdrawn addition in a five-word set. The top fill levels also push words into a full buffer. Each outcome is predicted by walking the fill count through the stated rules.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam logic [7:0] SKP_SYMBOL = 8'hAA;

  typedef struct packed {
    logic overflow;
    logic added;
    logic dropped;
  } ebuf_evt_t;
endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ebuf_wr_ctl.sv
module ebuf_wr_ctl
  import ebuf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int AF   = 12,
  parameter int AE   = 4,
  parameter int MAXW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_skp,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rgray_s,
  output logic          we0,
  output logic          we1,
  output logic [AW-1:0] waddr0,
  output logic [AW-1:0] waddr1,
  output logic [DW-1:0] wdata0,
  output logic [DW-1:0] wdata1,
  output logic [AW:0]   wgray,
  output ebuf_evt_t     evt
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(MAXW + 2);
  localparam logic [DW-1:0] SKP_WORD = {(DW/8){SKP_SYMBOL}};

  logic [PW-1:0] wptr_q, wptr_d, wpub_q, wpub_d, rbin, fill;
  logic [PW-1:0] wgray_q, wgray_d;
  logic          in_set_q, in_set_d, added_q, added_d, adj_q, adj_d;
  logic [CW-1:0] cnt_q, cnt_d;
  ebuf_evt_t     evt_q, evt_d;
  logic          skp_w, first_w, do_add, do_drop, surplus, full, lost;
  logic [1:0]    n_req, n_wr;

  // Gray to binary for the synchronized read pointer
  always_comb begin
    rbin[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
  end

  assign fill = wptr_q - rbin;
  assign full = (fill == PW'(DEPTH));

  // Decision logic
  always_comb begin
    skp_w   = wr_valid && wr_skp;
    first_w = skp_w && !in_set_q;
    do_add  = first_w && (fill <= PW'(AE));
    do_drop = skp_w && in_set_q && !adj_q && (fill >= PW'(AF));
    surplus = skp_w && in_set_q && added_q && (cnt_q == CW'(MAXW));
    if (!wr_valid || do_drop || surplus) n_req = 2'd0;
    else if (do_add)                     n_req = 2'd2;
    else                                 n_req = 2'd1;
    lost = (n_req != 2'd0) && full;
    n_wr = lost ? 2'd0 : n_req;
  end

  // Next state
  always_comb begin
    wptr_d   = wptr_q + PW'(n_wr);
    in_set_d = in_set_q;
    added_d  = added_q;
    adj_d    = adj_q;
    cnt_d    = cnt_q;
    evt_d    = evt_q;
    if (lost)    evt_d.overflow = 1'b1;
    if (do_drop) evt_d.dropped  = 1'b1;
    if (skp_w) begin
      in_set_d = 1'b1;
      cnt_d    = first_w ? CW'(n_wr) : cnt_q + CW'(n_wr);
      if (first_w) begin
        added_d = do_add;
        adj_d   = do_add;
      end
      if (do_drop) adj_d   = 1'b1;
      if (surplus) added_d = 1'b0;
    end else if (wr_valid && in_set_q) begin
      in_set_d = 1'b0;
      if (added_q) evt_d.added = 1'b1;
      added_d = 1'b0;
      adj_d   = 1'b0;
      cnt_d   = '0;
    end
    // published pointer trails the true one by at most one step per cycle
    wpub_d  = (wpub_q != wptr_q) ? wpub_q + PW'(1) : wpub_q;
    wgray_d = wpub_d ^ (wpub_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      wpub_q   <= '0;
      wgray_q  <= '0;
      in_set_q <= 1'b0;
      added_q  <= 1'b0;
      adj_q    <= 1'b0;
      cnt_q    <= '0;
      evt_q    <= '0;
    end else begin
      wptr_q   <= wptr_d;
      wpub_q   <= wpub_d;
      wgray_q  <= wgray_d;
      in_set_q <= in_set_d;
      added_q  <= added_d;
      adj_q    <= adj_d;
      cnt_q    <= cnt_d;
      evt_q    <= evt_d;
    end
  end

  assign we0    = (n_wr != 2'd0);
  assign we1    = (n_wr == 2'd2);
  assign waddr0 = wptr_q[AW-1:0];
  assign waddr1 = wptr_q[AW-1:0] + AW'(1);
  assign wdata0 = do_add ? SKP_WORD : wr_data;
  assign wdata1 = SKP_WORD;
  assign wgray  = wgray_q;
  assign evt    = evt_q;

  // R1: a valid data word with room is always stored exactly once
  a_r1_data_stored_once: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_skp && !full) |-> (we0 && !we1));

  // R10: the published Gray pointer moves by at most one bit per cycle
  a_r10_gray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));

  // R3: a double store advances the write pointer by two
  a_r3_add_advances_two: assert property (@(posedge clk) disable iff (!rst_n)
    we1 |=> (wptr_q == $past(wptr_q) + PW'(2)));

  // R7: the overflow flag never clears once set
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.overflow |=> evt_q.overflow);

  // R6: no second adjustment inside a set that has already been adjusted
  a_r6_one_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    (in_set_q && adj_q && wr_valid && wr_skp) |-> !we1);
endmodule

// File: rtl/ebuf_rd_ctl.sv
module ebuf_rd_ctl #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          underflow
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, rptr_d, wbin, rgray_q, rgray_d;
  logic          valid_q, valid_d, udf_q, udf_d, empty, pop;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    wbin[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
  end

  assign empty = (rptr_q == wbin);
  assign pop   = rd_en && !empty;

  always_comb begin
    rptr_d  = pop ? rptr_q + PW'(1) : rptr_q;
    rgray_d = rptr_d ^ (rptr_d >> 1);
    valid_d = pop;
    data_d  = pop ? mem_rdata : data_q;
    udf_d   = udf_q || (rd_en && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      udf_q   <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      rgray_q <= rgray_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      udf_q   <= udf_d;
    end
  end

  assign raddr     = rptr_q[AW-1:0];
  assign rgray     = rgray_q;
  assign rd_valid  = valid_q;
  assign rd_data   = data_q;
  assign underflow = udf_q;

  // R8: a request on an empty buffer yields no word and flags underflow
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> (!valid_q && udf_q));

  // R8: underflow is sticky
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q |=> udf_q);

  // R1: the read pointer only moves when a word is handed out
  a_r1_pop_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_q != $past(rptr_q)) |-> valid_q);
endmodule

// File: rtl/skp_elastic_buf.sv
module skp_elastic_buf
  import ebuf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int AF   = 12,
  parameter int AE   = 4,
  parameter int MAXW = 5
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          arst_n,
  input  logic          wr_valid,
  input  logic          wr_skp,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          sts_overflow,
  output logic          sts_underflow,
  output logic          sts_skp_added,
  output logic          sts_skp_dropped
);
  localparam int DEPTH = 1 << AW;

  logic          wrst_n, rrst_n;
  logic          we0, we1;
  logic [AW-1:0] waddr0, waddr1, raddr;
  logic [DW-1:0] wdata0, wdata1;
  logic [AW:0]   wgray, wgray_s, rgray, rgray_s;
  ebuf_evt_t     evt_w, evt_r;
  logic [DW-1:0] mem [DEPTH];

  // per-domain reset release
  ebuf_sync #(.W(1)) u_wrst (.clk(wr_clk), .rst_n(arst_n), .d(1'b1), .q(wrst_n));
  ebuf_sync #(.W(1)) u_rrst (.clk(rd_clk), .rst_n(arst_n), .d(1'b1), .q(rrst_n));

  ebuf_wr_ctl #(.DW(DW), .AW(AW), .AF(AF), .AE(AE), .MAXW(MAXW)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_valid(wr_valid), .wr_skp(wr_skp),
    .wr_data(wr_data), .rgray_s(rgray_s), .we0(we0), .we1(we1),
    .waddr0(waddr0), .waddr1(waddr1), .wdata0(wdata0), .wdata1(wdata1),
    .wgray(wgray), .evt(evt_w)
  );

  always_ff @(posedge wr_clk) begin
    if (we0) mem[waddr0] <= wdata0;
    if (we1) mem[waddr1] <= wdata1;
  end

  ebuf_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  ebuf_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  ebuf_sync #(.W(3))    u_evt (.clk(rd_clk), .rst_n(rrst_n), .d(evt_w), .q(evt_r));

  ebuf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .mem_rdata(mem[raddr]), .raddr(raddr), .rgray(rgray),
    .rd_valid(rd_valid), .rd_data(rd_data), .underflow(sts_underflow)
  );

  assign sts_overflow    = evt_r.overflow;
  assign sts_skp_added   = evt_r.added;
  assign sts_skp_dropped = evt_r.dropped;

  // R9: synchronized status flags stay set until reset
  a_r9_status_sticky: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (sts_skp_added |=> sts_skp_added));
endmodule

// File: tb/skp_elastic_buf_tb_top.sv
module skp_elastic_buf_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 11;
  localparam int WATCHDOG    = 150000;
  localparam logic [31:0] SKPW = 32'hAAAA_AAAA;

  logic wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b0;
  logic wr_valid = 1'b0, wr_skp = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_valid, sts_overflow, sts_underflow, sts_skp_added, sts_skp_dropped;
  logic [31:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] expq [64];
  int exp_n;

  always #(CLK_PERIOD/2)  wr_clk = ~wr_clk;
  always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

  skp_elastic_buf dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
    .wr_valid(wr_valid), .wr_skp(wr_skp), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .sts_overflow(sts_overflow), .sts_underflow(sts_underflow),
    .sts_skp_added(sts_skp_added), .sts_skp_dropped(sts_skp_dropped)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    arst_n = 1'b0;
    wr_valid = 1'b0; wr_skp = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge rd_clk);
    arst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic put(input logic skp, input logic [31:0] d);
    wr_valid = 1'b1; wr_skp = skp; wr_data = d;
    @(negedge wr_clk);
    wr_valid = 1'b0; wr_skp = 1'b0;
  endtask

  initial begin
    do_reset();
    // R9: reset state
    check("R9 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R9 flags", {28'd0, sts_overflow, sts_underflow, sts_skp_added, sts_skp_dropped}, 32'd0);

    for (int f = 0; f < 16; f++) begin
      for (int l = 1; l <= 5; l++) begin
        int cnt, setcnt;
        logic added, adj, e_ovf, e_add, e_drop;
        do_reset();
        exp_n = 0; cnt = 0; setcnt = 0;
        added = 1'b0; adj = 1'b0; e_ovf = 1'b0; e_add = 1'b0; e_drop = 1'b0;
        // prefill with data words
        for (int i = 0; i < f; i++) begin
          logic [31:0] d;
          d = {8'hD0, f[7:0], 8'h00, i[7:0]};
          put(1'b0, d);
          expq[exp_n] = d; exp_n++; cnt++;
        end
        // one SKP set of l words, model follows R2..R7
        for (int i = 0; i < l; i++) begin
          put(1'b1, SKPW);
          if (i == 0) begin
            if (cnt <= 4) begin
              expq[exp_n] = SKPW; expq[exp_n+1] = SKPW; exp_n += 2;
              cnt += 2; setcnt = 2; added = 1'b1; adj = 1'b1;
            end else if (cnt == 16) e_ovf = 1'b1;
            else begin
              expq[exp_n] = SKPW; exp_n++; cnt++; setcnt = 1;
            end
          end else if (!adj && cnt >= 12) begin
            adj = 1'b1; e_drop = 1'b1;
          end else if (added && setcnt == 5) begin
            added = 1'b0;
          end else if (cnt == 16) e_ovf = 1'b1;
          else begin
            expq[exp_n] = SKPW; exp_n++; cnt++; setcnt++;
          end
        end
        // closing word
        put(1'b0, {8'hE1, f[7:0], l[7:0], 8'h5A});
        if (added) e_add = 1'b1;
        if (cnt == 16) e_ovf = 1'b1;
        else begin
          expq[exp_n] = {8'hE1, f[7:0], l[7:0], 8'h5A}; exp_n++;
        end
        repeat (10) @(negedge rd_clk);
        // drain plus one extra read
        rd_en = 1'b1;
        for (int k = 0; k <= exp_n; k++) begin
          @(negedge rd_clk);
          if (k == exp_n) rd_en = 1'b0;
          if (k < exp_n) begin
            check("R1/R10 rd_valid", {31'd0, rd_valid}, 32'd1);
            check("R1 rd_data", rd_data, expq[k]);
          end else begin
            // R8: read on empty
            check("R8 rd_valid on empty", {31'd0, rd_valid}, 32'd0);
            check("R8 underflow", {31'd0, sts_underflow}, 32'd1);
          end
        end
        repeat (3) @(negedge rd_clk);
        // R3, R5 add flag; R2, R4, R6 drop flag; R7 overflow
        check("R3/R5 added", {31'd0, sts_skp_added}, {31'd0, e_add});
        check("R2/R4/R6 dropped", {31'd0, sts_skp_dropped}, {31'd0, e_drop});
        check("R7 overflow", {31'd0, sts_overflow}, {31'd0, e_ovf});
        check("R9 underflow sticky", {31'd0, sts_underflow}, 32'd1);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule